// File: doc/BRIEF.md
# Last-Outcome Branch Target Predictor

This block sits next to the fetch address logic of a simple in-order pipeline and chooses the next fetch address every cycle. The fetch PC is looked up in a direct-mapped table of `2**IDX_W` entries (16 by default). The index is PC bits `[IDX_W+1:2]`. Each entry holds a valid bit, a tag made of the PC bits above the index, a one-bit record of the branch's most recent direction, and the signed byte offset that the branch jumps by. A hit whose bit says taken predicts `fetch PC + offset`. A miss, or a hit whose bit says not taken, predicts the sequential address `fetch PC + 4`.

Branches are resolved later in the execute stage. The execute stage returns the branch PC, its real direction and offset, its fall-through PC, and the prediction made for it at fetch (the taken flag and the predicted next PC). A wrong direction, or a taken branch whose predicted next PC differs from `branch PC + offset`, is a mispredict. A mispredict requests a flush for one cycle, together with the corrected PC, and rewrites the branch's entry. A resolved branch that missed in the table takes its entry whether or not it was mispredicted, and evicts any branch that held that index.

A two-state machine orders the flush. In RUN no flush is requested. A resolve that is a mispredict moves it to FLUSH, which drives the flush strobe and the corrected PC for one cycle. FLUSH returns to RUN unless another mispredict arrives in that cycle, in which case it stays in FLUSH with the new corrected PC. A synchronous reset returns it to RUN and clears every valid bit.

Top module: `lobp_top`

## Requirements
- R1: When the fetch PC misses (no valid entry, a different tag, or a PC whose bits [1:0] are not 00), `pred_taken_o` is 0 and `pred_pc_o` equals `fetch_pc_i + 4` in the same cycle.
- R2: When the fetch PC hits an entry whose direction bit is taken, `pred_taken_o` is 1 and `pred_pc_o` equals `fetch_pc_i` plus the stored offset, with no cycle of delay.
- R3: When the fetch PC hits an entry whose direction bit is not taken, `pred_taken_o` is 0 and `pred_pc_o` equals `fetch_pc_i + 4`.
- R4: A valid resolve whose actual direction differs from its carried predicted direction raises `flush_o` in the next cycle. `fix_pc_o` is then `rsv_pc_i + rsv_off_i` if the branch was taken, or `rsv_seq_pc_i` if it was not.
- R5: A valid resolve that was predicted taken and is taken, but whose carried predicted next PC is not `rsv_pc_i + rsv_off_i`, raises `flush_o` in the next cycle with `fix_pc_o` equal to that target.
- R6: A valid resolve whose direction and (if taken) target match the carried prediction leaves `flush_o` low in the next cycle.
- R7: After a mispredicted resolve, a later lookup of that branch PC returns the resolved direction and, if taken, the resolved offset.
- R8: A resolved branch that missed in the table is written into its index even when correctly predicted. A different branch that held that index misses afterwards.
- R9: A synchronous reset clears every valid bit and the flush state, so the first lookups after reset predict not taken.
- R10: When a resolve write and a fetch lookup address the same entry in one cycle, the lookup returns the contents from before the write.
- R11: `flush_o` is high for exactly one cycle per mispredict: a cycle without a valid resolve is followed by `flush_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc_i | input | PC_W | Current fetch address |
| rsv_valid_i | input | 1 | A branch resolution is presented this cycle |
| rsv_pc_i | input | PC_W | Address of the resolved branch |
| rsv_taken_i | input | 1 | Actual direction of the resolved branch |
| rsv_off_i | input | PC_W | Signed byte offset of the resolved branch |
| rsv_seq_pc_i | input | PC_W | Fall-through address of the resolved branch |
| rsv_pred_taken_i | input | 1 | Direction predicted for this branch at fetch |
| rsv_pred_next_i | input | PC_W | Next PC predicted for this branch at fetch |
| pred_pc_o | output | PC_W | Predicted next fetch address |
| pred_taken_o | output | 1 | Prediction is taken |
| flush_o | output | 1 | One-cycle request to flush the pipeline |
| fix_pc_o | output | PC_W | Corrected fetch address, valid with flush_o |

## Verification
A lookup of the current fetch PC and a resolve write can land on the same table entry in one cycle. The bench sets this up by presenting a mispredicted resolve for a branch while fetching that same branch. The scoreboard expects that cycle's prediction to come from the old entry and the next lookup to come from the new one. A mispredict can also arrive while the machine is already in FLUSH. Back-to-back resolves check that the flush strobe tracks each resolve separately.

// File: rtl/lobp_pkg.sv
package lobp_pkg;
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rs_state_e;

    localparam int ALIGN_W = 2;
endpackage

// File: rtl/lobp_table.sv
module lobp_table
    import lobp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_off,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    input  logic            wr_en,
    input  logic            wr_taken,
    input  logic [PC_W-1:0] wr_off
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int LO    = ALIGN_W;
    localparam int TAG_W = PC_W - IDX_W - LO;

    typedef struct packed {
        logic             v;
        logic             tk;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  off;
    } ent_t;

    ent_t tbl [DEPTH];

    logic [IDX_W-1:0] lk_idx, rd_idx;
    ent_t             lk_ent, rd_ent;

    always_comb begin
        lk_idx   = lk_pc[IDX_W+LO-1:LO];
        rd_idx   = rd_pc[IDX_W+LO-1:LO];
        lk_ent   = tbl[lk_idx];
        rd_ent   = tbl[rd_idx];
        lk_hit   = lk_ent.v && (lk_ent.tag == lk_pc[PC_W-1:IDX_W+LO])
                   && (lk_pc[LO-1:0] == '0);
        lk_taken = lk_ent.tk;
        lk_off   = lk_ent.off;
        rd_hit   = rd_ent.v && (rd_ent.tag == rd_pc[PC_W-1:IDX_W+LO])
                   && (rd_pc[LO-1:0] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i].v <= 1'b0;
        end else if (wr_en) begin
            tbl[rd_idx] <= '{v: 1'b1, tk: wr_taken,
                             tag: rd_pc[PC_W-1:IDX_W+LO], off: wr_off};
        end
    end

    // R7: a written branch is seen on the fetch port from the next cycle
    p_learn_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && lk_pc == $past(rd_pc) && lk_pc[LO-1:0] == '0)
        |-> (lk_hit && lk_taken == $past(wr_taken)));
endmodule

// File: rtl/lobp_resolver.sv
module lobp_resolver
    import lobp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_off,
    input  logic [PC_W-1:0] rsv_seq,
    input  logic            rsv_pred_taken,
    input  logic [PC_W-1:0] rsv_pred_next,
    input  logic            rsv_hit,
    output logic            wr_en,
    output logic            flush_o,
    output logic [PC_W-1:0] fix_pc_o
);
    rs_state_e       st, st_nxt;
    logic [PC_W-1:0] target, correct, fix_q;
    logic            mis;

    always_comb begin
        target  = rsv_pc + rsv_off;
        correct = rsv_taken ? target : rsv_seq;
        mis     = rsv_valid && ((rsv_pred_taken != rsv_taken) ||
                                (rsv_taken && rsv_pred_next != target));
        wr_en   = rsv_valid && (mis || !rsv_hit);
        unique case (st)
            ST_RUN:   st_nxt = mis ? ST_FLUSH : ST_RUN;
            ST_FLUSH: st_nxt = mis ? ST_FLUSH : ST_RUN;
            default:  st_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_RUN;
            fix_q <= '0;
        end else begin
            st <= st_nxt;
            if (mis) fix_q <= correct;
        end
    end

    always_comb begin
        flush_o  = (st == ST_FLUSH);
        fix_pc_o = fix_q;
    end

    // R4: a flush always follows a resolve
    p_flush_cause_r4: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(rsv_valid));
    // R4: direction mispredict of a not-taken branch redirects to fall-through
    p_fix_seq_r4: assert property (@(posedge clk) disable iff (rst)
        (flush_o && !$past(rsv_taken)) |-> fix_pc_o == $past(rsv_seq));
    // R5: taken branch redirects to its own target
    p_fix_target_r5: assert property (@(posedge clk) disable iff (rst)
        (flush_o && $past(rsv_taken)) |-> fix_pc_o == $past(rsv_pc + rsv_off));
    // R6: a matching prediction never flushes
    p_no_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (rsv_valid && rsv_pred_taken == rsv_taken &&
         (!rsv_taken || rsv_pred_next == rsv_pc + rsv_off)) |=> !flush_o);
    // R11: flush is a single-cycle strobe
    p_single_r11: assert property (@(posedge clk) disable iff (rst)
        !rsv_valid |=> !flush_o);
endmodule

// File: rtl/lobp_top.sv
module lobp_top
    import lobp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            rsv_valid_i,
    input  logic [PC_W-1:0] rsv_pc_i,
    input  logic            rsv_taken_i,
    input  logic [PC_W-1:0] rsv_off_i,
    input  logic [PC_W-1:0] rsv_seq_pc_i,
    input  logic            rsv_pred_taken_i,
    input  logic [PC_W-1:0] rsv_pred_next_i,
    output logic [PC_W-1:0] pred_pc_o,
    output logic            pred_taken_o,
    output logic            flush_o,
    output logic [PC_W-1:0] fix_pc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN_W);

    logic            lk_hit, lk_taken, rd_hit, wr_en;
    logic [PC_W-1:0] lk_off;

    lobp_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (fetch_pc_i),
        .lk_hit   (lk_hit),
        .lk_taken (lk_taken),
        .lk_off   (lk_off),
        .rd_pc    (rsv_pc_i),
        .rd_hit   (rd_hit),
        .wr_en    (wr_en),
        .wr_taken (rsv_taken_i),
        .wr_off   (rsv_off_i)
    );

    lobp_resolver #(.PC_W(PC_W)) u_resolver (
        .clk            (clk),
        .rst            (rst),
        .rsv_valid      (rsv_valid_i),
        .rsv_pc         (rsv_pc_i),
        .rsv_taken      (rsv_taken_i),
        .rsv_off        (rsv_off_i),
        .rsv_seq        (rsv_seq_pc_i),
        .rsv_pred_taken (rsv_pred_taken_i),
        .rsv_pred_next  (rsv_pred_next_i),
        .rsv_hit        (rd_hit),
        .wr_en          (wr_en),
        .flush_o        (flush_o),
        .fix_pc_o       (fix_pc_o)
    );

    always_comb begin
        pred_taken_o = lk_hit && lk_taken;
        pred_pc_o    = pred_taken_o ? (fetch_pc_i + lk_off) : (fetch_pc_i + STEP);
    end

    // R1/R3: a not-taken prediction is always the sequential address
    p_seq_r1: assert property (@(posedge clk) disable iff (rst)
        !pred_taken_o |-> pred_pc_o == fetch_pc_i + STEP);
    // R9: nothing survives a reset
    p_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_taken_o && !flush_o));
endmodule

// File: tb/lobp_top_tb_top.sv
module lobp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, rsv_pc, rsv_off, rsv_seq, rsv_pred_next;
    logic        rsv_valid, rsv_taken, rsv_pred_taken;
    logic [31:0] pred_pc, fix_pc;
    logic        pred_taken, flush;

    always #2.5 clk = ~clk;

    lobp_top dut_i (
        .clk(clk), .rst(rst), .fetch_pc_i(fetch_pc),
        .rsv_valid_i(rsv_valid), .rsv_pc_i(rsv_pc), .rsv_taken_i(rsv_taken),
        .rsv_off_i(rsv_off), .rsv_seq_pc_i(rsv_seq),
        .rsv_pred_taken_i(rsv_pred_taken), .rsv_pred_next_i(rsv_pred_next),
        .pred_pc_o(pred_pc), .pred_taken_o(pred_taken),
        .flush_o(flush), .fix_pc_o(fix_pc)
    );

    typedef struct {
        int          cyc;
        bit          is_flush;
        logic [31:0] exp_pc;
        logic        exp_bit;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // monitor: pops expectations whose cycle has come
    initial forever begin
        @(negedge clk);
        #1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (!it.is_flush) begin
                if (pred_pc !== it.exp_pc || pred_taken !== it.exp_bit) begin
                    n_fail++;
                    $display("FAIL %s: pred_pc=%h taken=%b expected pred_pc=%h taken=%b",
                             it.req, pred_pc, pred_taken, it.exp_pc, it.exp_bit);
                end
            end else begin
                if (flush !== it.exp_bit || (it.exp_bit && fix_pc !== it.exp_pc)) begin
                    n_fail++;
                    $display("FAIL %s: flush=%b fix_pc=%h expected flush=%b fix_pc=%h",
                             it.req, flush, fix_pc, it.exp_bit, it.exp_pc);
                end
            end
        end
    end

    task automatic push(int c, bit f, logic [31:0] pc, logic b, string r);
        item_t it;
        it.cyc = c; it.is_flush = f; it.exp_pc = pc; it.exp_bit = b; it.req = r;
        q.push_back(it);
    endtask

    task automatic do_reset(string r);
        @(negedge clk);
        rst = 1'b1; rsv_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(cyc, 1'b1, 32'h0, 1'b0, r);
    endtask

    // lookup only; also expects no flush in the following cycle (R11)
    task automatic lookup(logic [31:0] pc, logic [31:0] epc, logic etk, string r);
        @(negedge clk);
        fetch_pc = pc; rsv_valid = 1'b0;
        push(cyc, 1'b0, epc, etk, r);
        push(cyc + 1, 1'b1, 32'h0, 1'b0, "R11");
    endtask

    task automatic resolve(logic [31:0] bpc, logic tk, logic [31:0] off, logic [31:0] seq,
                           logic ptk, logic [31:0] pnext, logic efl, logic [31:0] efix,
                           string r);
        @(negedge clk);
        rsv_valid = 1'b1; rsv_pc = bpc; rsv_taken = tk; rsv_off = off;
        rsv_seq = seq; rsv_pred_taken = ptk; rsv_pred_next = pnext;
        push(cyc + 1, 1'b1, efix, efl, r);
    endtask

    initial begin
        rst = 1'b1; fetch_pc = 32'h0; rsv_valid = 1'b0; rsv_pc = 32'h0;
        rsv_taken = 1'b0; rsv_off = 32'h0; rsv_seq = 32'h0;
        rsv_pred_taken = 1'b0; rsv_pred_next = 32'h0;

        do_reset("R9");
        lookup(32'h1008, 32'h100C, 1'b0, "R9 R1 empty table");
        lookup(32'h100A, 32'h100E, 1'b0, "R1 misaligned");
        // direction mispredict, learn taken
        resolve(32'h1008, 1'b1, 32'h40, 32'h100C, 1'b0, 32'h100C, 1'b1, 32'h1048, "R4 taken");
        lookup(32'h1008, 32'h1048, 1'b1, "R2 R7");
        // correct prediction
        resolve(32'h1008, 1'b1, 32'h40, 32'h100C, 1'b1, 32'h1048, 1'b0, 32'h0, "R6");
        // target mismatch, back-to-back resolve
        resolve(32'h1008, 1'b1, 32'h80, 32'h100C, 1'b1, 32'h1048, 1'b1, 32'h1088, "R5");
        lookup(32'h1008, 32'h1088, 1'b1, "R7 new offset");
        // learn not taken
        resolve(32'h1008, 1'b0, 32'h80, 32'h100C, 1'b1, 32'h1088, 1'b1, 32'h100C, "R4 not taken");
        lookup(32'h1008, 32'h100C, 1'b0, "R3");
        resolve(32'h1008, 1'b1, 32'h20, 32'h100C, 1'b0, 32'h100C, 1'b1, 32'h1028, "R4");
        lookup(32'h1008, 32'h1028, 1'b1, "R2");
        // conflicting branch at same index evicts the first
        resolve(32'h1048, 1'b1, 32'h100, 32'h104C, 1'b0, 32'h104C, 1'b1, 32'h1148, "R4");
        lookup(32'h1008, 32'h100C, 1'b0, "R8 evicted");
        lookup(32'h1048, 32'h1148, 1'b1, "R8 occupant");
        // correctly predicted miss still allocates (negative offset)
        resolve(32'h3018, 1'b1, 32'hFFFF_FFF8, 32'h301C, 1'b1, 32'h3010, 1'b0, 32'h0, "R6");
        lookup(32'h3018, 32'h3010, 1'b1, "R8 allocate");
        // same-cycle write and lookup on one entry
        @(negedge clk);
        fetch_pc = 32'h1048;
        rsv_valid = 1'b1; rsv_pc = 32'h1048; rsv_taken = 1'b0; rsv_off = 32'h100;
        rsv_seq = 32'h104C; rsv_pred_taken = 1'b1; rsv_pred_next = 32'h1148;
        push(cyc, 1'b0, 32'h1148, 1'b1, "R10 old contents");
        push(cyc + 1, 1'b1, 32'h104C, 1'b1, "R10 flush");
        lookup(32'h1048, 32'h104C, 1'b0, "R10 new contents");
        // reset clears learned entries
        do_reset("R9");
        lookup(32'h3018, 32'h301C, 1'b0, "R9 cleared");
        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule